// File: doc/BRIEF.md
# Logical-Block Sector Reader with Memory Push

This block serves read requests for a modelled disk. A processor loads a logical block number and a destination byte address into two register slots, then writes a read command to a third slot. The block checks the block number against the disk's capacity and splits it into a (surface, track, sector) triple. It then pushes every word of that sector into main memory through a valid/ready write port. The processor takes no part in the transfer. When the last word has been taken, the block raises an interrupt, which stays up until the processor writes the acknowledge slot.

The disk geometry (surfaces, tracks per surface, sectors per track) and the sector size are parameters; the default sector holds 512 bytes. Sector contents come from a computed store: each word encodes where it lives, so any word landing in memory shows which sector and which offset produced it. An out-of-range block number produces no memory traffic. It sets an error flag and raises the interrupt at once.

Top module: `blkdma_ctrl`

## Requirements
- R1: During and right after reset, busy, err, irq and mem_valid are low.
- R2: A register write with reg_addr 0 loads the block number and reg_addr 1 loads the destination byte address. A write to reg_addr 2 whose bits [7:0] equal 0x01 is accepted when busy is low, and busy is high in the next cycle.
- R3: A command write whose bits [7:0] hold any code other than 0x01 starts nothing: busy and mem_valid stay low.
- R4: A command written while busy is high is ignored. So are block-number and address writes made during a transfer: the running transfer still moves exactly one sector from the values captured at acceptance.
- R5: Block number b maps to sector = b mod SECTORS, track = (b / SECTORS) mod TRACKS, surface = b / (SECTORS*TRACKS).
- R6: Word i of a sector is {surface[7:0], track[7:0], sector[7:0], i[7:0]}, from bit 31 down to bit 0.
- R7: mem_valid rises the cycle after acceptance. The first address is the captured destination, and each accepted word (mem_valid and mem_ready both high at a clock edge) advances the address by 4. Address and data hold while mem_ready is low, and SECTOR_BYTES/4 words are sent.
- R8: busy stays high from the cycle after acceptance until the cycle after the last word is accepted. irq is high when busy falls.
- R9: A block number at or above SURFACES*TRACKS*SECTORS sets err and irq in the cycle after the command, with busy and mem_valid remaining low.
- R10: irq holds until a write to reg_addr 3. If that write lands in the same cycle as a completion, irq stays high.
- R11: err clears when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register slot: 0 block, 1 destination, 2 command, 3 acknowledge |
| reg_wdata | input | 32 | Register write data |
| mem_valid | output | 1 | Memory write word present |
| mem_ready | input | 1 | Memory accepts the word |
| mem_addr | output | 32 | Memory byte address of the word |
| mem_data | output | 32 | Memory write word |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Last accepted command named a block beyond capacity |
| irq | output | 1 | Interrupt to the processor |

## Verification
The bench goes after the edges of a transfer. It stalls the memory port in irregular patterns, and a design that moved the address or data while stalled, or counted a word that was never accepted, would write the wrong place or send too few words. It sends a second command and rewrites the block number in mid-transfer; a design that did not latch its operands at acceptance would switch sectors part way or start over. It asks for the highest valid block and the first invalid one, where an off-by-one capacity test either drops a real sector or reads past the disk. It also lands an acknowledge on the very edge of completion, where a clear that wins over the set would lose the interrupt.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BYTES_PER_WORD = DATA_W / 8;

    typedef enum logic [1:0] {
        SLOT_BLOCK = 2'd0,
        SLOT_DEST  = 2'd1,
        SLOT_CMD   = 2'd2,
        SLOT_ACK   = 2'd3
    } reg_slot_e;

    localparam logic [7:0] OP_READ = 8'h01;

    typedef struct packed {
        logic [7:0] surf;
        logic [7:0] trk;
        logic [7:0] sec;
    } chs_t;

    typedef enum logic {
        MV_IDLE,
        MV_PUSH
    } mover_state_e;

    // Computed sector store: each word names its own location.
    function automatic logic [DATA_W-1:0] sector_word(chs_t loc, logic [7:0] idx);
        return {loc.surf, loc.trk, loc.sec, idx};
    endfunction

endpackage

// File: rtl/blkdma_regs.sv
module blkdma_regs
    import blkdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              busy,
    output logic [DATA_W-1:0] block_q,
    output logic [ADDR_W-1:0] dest_q,
    output logic              go,
    output logic              ack
);

    always_ff @(posedge clk) begin
        if (rst) begin
            block_q <= '0;
            dest_q  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == SLOT_BLOCK) block_q <= reg_wdata;
            if (reg_addr == SLOT_DEST)  dest_q  <= reg_wdata;
        end
    end

    always_comb begin
        go  = reg_wr && (reg_addr == SLOT_CMD) && (reg_wdata[7:0] == OP_READ) && !busy;
        ack = reg_wr && (reg_addr == SLOT_ACK);
    end

endmodule

// File: rtl/blkdma_xlate.sv
module blkdma_xlate
    import blkdma_pkg::*;
#(
    parameter int SURFACES = 2,
    parameter int TRACKS   = 2,
    parameter int SECTORS  = 4,
    parameter int LBN_W    = 32
) (
    input  logic [LBN_W-1:0] block,
    output chs_t             loc,
    output logic             in_range
);

    localparam int PER_SURF = TRACKS * SECTORS;
    localparam int CAPACITY = SURFACES * PER_SURF;
    localparam logic [LBN_W-1:0] SEC_C  = LBN_W'(SECTORS);
    localparam logic [LBN_W-1:0] TRK_C  = LBN_W'(TRACKS);
    localparam logic [LBN_W-1:0] SURF_C = LBN_W'(PER_SURF);
    localparam logic [LBN_W-1:0] CAP_C  = LBN_W'(CAPACITY);

    logic [LBN_W-1:0] sec_full, trk_full, surf_full;

    always_comb begin
        sec_full  = block % SEC_C;
        trk_full  = (block / SEC_C) % TRK_C;
        surf_full = block / SURF_C;
        loc.sec   = sec_full[7:0];
        loc.trk   = trk_full[7:0];
        loc.surf  = surf_full[7:0];
        in_range  = block < CAP_C;
    end

endmodule

// File: rtl/blkdma_mover.sv
module blkdma_mover
    import blkdma_pkg::*;
#(
    parameter int WORDS = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_dest,
    input  chs_t              start_loc,
    input  logic              mem_ready,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              busy,
    output logic              done
);

    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    mover_state_e     state;
    logic [IDX_W-1:0] idx;
    logic [ADDR_W-1:0] addr_q;
    chs_t             loc_q;
    logic             take;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= MV_IDLE;
            idx    <= '0;
            addr_q <= '0;
            loc_q  <= '0;
        end else begin
            case (state)
                MV_IDLE: if (start) begin
                    state  <= MV_PUSH;
                    idx    <= '0;
                    addr_q <= start_dest;
                    loc_q  <= start_loc;
                end
                MV_PUSH: if (mem_ready) begin
                    if (idx == LAST_IDX) begin
                        state <= MV_IDLE;
                    end else begin
                        idx    <= idx + 1'b1;
                        addr_q <= addr_q + ADDR_W'(BYTES_PER_WORD);
                    end
                end
                default: state <= MV_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_valid = (state == MV_PUSH);
        busy      = (state == MV_PUSH);
        take      = mem_valid && mem_ready;
        done      = take && (idx == LAST_IDX);
        mem_addr  = addr_q;
        mem_data  = sector_word(loc_q, 8'(idx));
    end

endmodule

// File: rtl/blkdma_ctrl.sv
module blkdma_ctrl
    import blkdma_pkg::*;
#(
    parameter int SURFACES     = 2,
    parameter int TRACKS       = 2,
    parameter int SECTORS      = 4,
    parameter int SECTOR_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              busy,
    output logic              err,
    output logic              irq
);

    localparam int WORDS = SECTOR_BYTES / BYTES_PER_WORD;

    logic [DATA_W-1:0] block_q;
    logic [ADDR_W-1:0] dest_q;
    logic              go, ack, in_range, done;
    chs_t              loc;

    blkdma_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .block_q(block_q),
        .dest_q(dest_q), .go(go), .ack(ack)
    );

    blkdma_xlate #(
        .SURFACES(SURFACES), .TRACKS(TRACKS), .SECTORS(SECTORS), .LBN_W(DATA_W)
    ) u_xlate (
        .block(block_q), .loc(loc), .in_range(in_range)
    );

    blkdma_mover #(.WORDS(WORDS)) u_mover (
        .clk(clk), .rst(rst), .start(go && in_range), .start_dest(dest_q),
        .start_loc(loc), .mem_ready(mem_ready), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy), .done(done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
            err <= 1'b0;
        end else begin
            if (ack) irq <= 1'b0;
            // a raise in the same cycle as an acknowledge wins
            if (done || (go && !in_range)) irq <= 1'b1;
            if (go) err <= !in_range;
        end
    end

endmodule

// File: rtl/blkdma_chk.sv
module blkdma_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic        mem_valid,
    input logic        mem_ready,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_data,
    input logic        busy,
    input logic        err,
    input logic        irq
);

    p_hold_stall_r7: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
        mem_valid && $past(mem_valid && mem_ready) |-> mem_addr == $past(mem_addr) + 32'd4);

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> !mem_valid && !busy);

    p_irq_hold_r10: assert property (@(posedge clk) disable iff (rst)
        irq && !(reg_wr && reg_addr == 2'd3) |=> irq);

    p_finish_irq_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq);

endmodule

bind blkdma_ctrl blkdma_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .busy(busy), .err(err), .irq(irq)
);

// File: tb/sim_blkdma_ctrl.sv
module sim_blkdma_ctrl;

    localparam int SURF  = 2;
    localparam int TRK   = 2;
    localparam int SEC   = 4;
    localparam int WORDS = 128;
    localparam int CAP   = SURF * TRK * SEC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        mem_ready = 1'b0;
    logic        mem_valid, busy, err, irq;
    logic [31:0] mem_addr, mem_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int obs_hs = 0;

    always #5 clk = ~clk;

    blkdma_ctrl u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy), .err(err), .irq(irq)
    );

    // Behavioural reference model
    bit m_busy, m_irq, m_err;
    int m_idx, m_blk;
    logic [31:0] m_dest, m_lreg, m_dreg;

    always @(posedge clk) begin
        bit acc, bad, fin;
        if (rst) begin
            m_busy = 0; m_irq = 0; m_err = 0; m_idx = 0; m_blk = 0;
            m_dest = 0; m_lreg = 0; m_dreg = 0;
        end else begin
            acc = reg_wr && reg_addr == 2'd2 && reg_wdata[7:0] == 8'h01 && !m_busy;
            bad = m_lreg >= CAP;
            fin = m_busy && mem_ready && m_idx == WORDS - 1;
            if (reg_wr && reg_addr == 2'd3) m_irq = 0;
            if (fin || (acc && bad)) m_irq = 1;
            if (acc) m_err = bad;
            if (fin) m_busy = 0;
            else if (m_busy && mem_ready) m_idx++;
            if (acc && !bad) begin
                m_busy = 1; m_idx = 0; m_dest = m_dreg; m_blk = int'(m_lreg);
            end
            if (reg_wr && reg_addr == 2'd0) m_lreg = reg_wdata;
            if (reg_wr && reg_addr == 2'd1) m_dreg = reg_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare();
        logic [31:0] exp_data;
        string tag;
        tag = rst ? "R1" : "R8 busy";
        chk(busy == m_busy, tag, 32'(busy), 32'(m_busy));
        chk(irq == m_irq, rst ? "R1" : "R10 irq", 32'(irq), 32'(m_irq));
        chk(err == m_err, rst ? "R1" : "R9 err", 32'(err), 32'(m_err));
        chk(mem_valid == m_busy, rst ? "R1" : "R7 valid", 32'(mem_valid), 32'(m_busy));
        if (m_busy) begin
            exp_data = {8'(m_blk / (SEC * TRK)), 8'((m_blk / SEC) % TRK), 8'(m_blk % SEC), 8'(m_idx)};
            chk(mem_addr == m_dest + 32'(4 * m_idx), "R7 addr", mem_addr, m_dest + 32'(4 * m_idx));
            chk(mem_data == exp_data, "R6 data", mem_data, exp_data);
        end
    endtask

    task automatic cyc(input bit r, input bit wr, input logic [1:0] a, input logic [31:0] d, input bit rdy);
        @(negedge clk);
        compare();
        rst = r; reg_wr = wr; reg_addr = a; reg_wdata = d; mem_ready = rdy;
        if (!r && mem_valid && rdy) obs_hs++;
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy) begin
            cyc(0, 0, 2'd0, 32'd0, (k % 3) != 0);
            k++;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL R8 watchdog actual=%0d expected<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) cyc(1, 0, 2'd0, 32'd0, 1'b0);
        cyc(0, 0, 2'd0, 32'd0, 1'b0);
        chk(!busy && !irq && !err && !mem_valid, "R1 reset state", {28'd0, busy, irq, err, mem_valid}, 32'd0);

        // Normal transfer of block 5 with irregular ready
        cyc(0, 1, 2'd0, 32'd5, 1'b0);
        cyc(0, 1, 2'd1, 32'h1000, 1'b0);
        cyc(0, 1, 2'd2, 32'h01, 1'b0);
        obs_hs = 0;
        cyc(0, 0, 2'd0, 32'd0, 1'b0);
        chk(busy == 1'b1, "R2 command accepted", 32'(busy), 32'd1);
        chk(mem_data == 32'h00010100, "R5 block 5 first word", mem_data, 32'h00010100);
        chk(mem_addr == 32'h1000, "R7 first address", mem_addr, 32'h1000);
        wait_idle();
        chk(obs_hs == WORDS, "R7 word count", 32'(obs_hs), 32'(WORDS));
        chk(irq == 1'b1, "R8 irq at finish", 32'(irq), 32'd1);
        cyc(0, 1, 2'd3, 32'd0, 1'b0);
        cyc(0, 0, 2'd0, 32'd0, 1'b0);
        chk(irq == 1'b0, "R10 ack clears", 32'(irq), 32'd0);

        // Wrong command code
        cyc(0, 1, 2'd2, 32'h02, 1'b1);
        cyc(0, 0, 2'd0, 32'd0, 1'b1);
        chk(!busy && !mem_valid, "R3 bad code ignored", {30'd0, busy, mem_valid}, 32'd0);

        // Last valid block, with interference during the transfer
        cyc(0, 1, 2'd0, 32'd15, 1'b0);
        cyc(0, 1, 2'd1, 32'h2000, 1'b0);
        cyc(0, 1, 2'd2, 32'h01, 1'b0);
        obs_hs = 0;
        cyc(0, 0, 2'd0, 32'd0, 1'b1);
        cyc(0, 1, 2'd0, 32'd3, 1'b0);
        cyc(0, 1, 2'd1, 32'h5000, 1'b1);
        cyc(0, 1, 2'd2, 32'h01, 1'b1);
        cyc(0, 0, 2'd0, 32'd0, 1'b0);
        chk(mem_data[31:8] == 24'h010103, "R5 block 15 triple", {8'd0, mem_data[31:8]}, 32'h010103);
        wait_idle();
        chk(obs_hs == WORDS, "R4 one sector only", 32'(obs_hs), 32'(WORDS));
        cyc(0, 0, 2'd0, 32'd0, 1'b0);
        chk(!busy && irq, "R4 no restart", {30'd0, busy, irq}, 32'd1);

        // First out-of-range block, issued while irq still pending
        cyc(0, 1, 2'd0, CAP, 1'b1);
        cyc(0, 1, 2'd2, 32'h01, 1'b1);
        cyc(0, 0, 2'd0, 32'd0, 1'b1);
        chk(err && irq && !busy && !mem_valid, "R9 range error",
            {28'd0, err, irq, busy, mem_valid}, 32'b1100);
        cyc(0, 1, 2'd3, 32'd0, 1'b1);
        cyc(0, 0, 2'd0, 32'd0, 1'b1);
        chk(!irq && err, "R9 err holds after ack", {30'd0, irq, err}, 32'd1);

        // Block 0 at full speed, acknowledge on the completion edge
        cyc(0, 1, 2'd0, 32'd0, 1'b1);
        cyc(0, 1, 2'd1, 32'h3000, 1'b1);
        cyc(0, 1, 2'd2, 32'h01, 1'b1);
        for (int i = 0; i < WORDS - 1; i++) begin
            cyc(0, 0, 2'd0, 32'd0, 1'b1);
            if (i == 0) chk(err == 1'b0, "R11 err cleared", 32'(err), 32'd0);
        end
        cyc(0, 1, 2'd3, 32'd0, 1'b1);
        cyc(0, 0, 2'd0, 32'd0, 1'b1);
        chk(!busy && irq, "R10 set beats ack", {30'd0, busy, irq}, 32'd1);

        repeat (3) cyc(0, 0, 2'd0, 32'd0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule